// File: doc/BRIEF.md
# PCI Slot Interrupt Router

This block turns an interrupt request from a PCI device into a number on the host's internal interrupt scheme, and then drives the single interrupt line toward the CPU. A request names the slot it comes from and the interrupt pin it raised (pins 0 to 3). A fixed board map turns that pair into an internal interrupt number. The on-board multifunction controller in slot 5 gets four lines. The video slot 6 and the network slot 7 each get one line. The expansion slots 8 to 12 share a rotated set of lines. A slot outside the map gets its pin number back unchanged, and that value falls below the internal base.

Internal numbers start at 32. The internal line index is the mapped number minus 32, and it selects one bit of two 32-bit configuration words: an edge-select word and a polarity word. On a request for an edge-selected line, the CPU line gives a one-cycle pulse. On a request for any other line, the CPU line is set to that line's polarity bit, and it keeps that level until the next request that touches it. Status latching and enable masking are done outside this block.

The mapped number follows the slot and pin inputs combinationally. The CPU line is a register, so a request's effect appears one clock after the request strobe.

Top module: `pci_irq_router`

## Requirements
- R1: After synchronous reset the CPU line `cpu_irq` is low.
- R2: Slot 5 maps pin p to 32 + (p mod 4), giving 32 to 35.
- R3: Slot 6 maps every pin to 36, and slot 7 maps every pin to 37.
- R4: Slots 8 to 12 map pin p to 38 + (slot - 8) + p, giving 38 to 45.
- R5: Every other slot maps pin p to p itself, a value below 32.
- R6: When a request strobe hits a mapped line whose edge-select bit (bit number = mapped - 32) is 1, `cpu_irq` is 1 in the next cycle. In the cycle after that it is 0, unless a new request arrives.
- R7: When a request hits a mapped line whose edge-select bit is 0 and whose polarity bit is 1, `cpu_irq` is 1 from the next cycle on.
- R8: When a request hits a mapped line whose edge-select bit is 0 and whose polarity bit is 0, `cpu_irq` is 0 from the next cycle on. Only the bit at that line's index is consulted.
- R9: With no request, a level set by R7 or R8 holds, even when the edge-select or polarity words change.
- R10: A request whose mapped number is below 32 leaves `cpu_irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Interrupt request strobe, one cycle per event |
| req_slot | input | 5 | Slot number of the requesting device |
| req_pin | input | 2 | Interrupt pin raised (0 to 3) |
| edge_sel | input | 32 | Per-line select: 1 means pulse, 0 means level |
| line_pol | input | 32 | Per-line level driven in level mode |
| mapped_num | output | 6 | Mapped interrupt number for the current slot and pin |
| cpu_irq | output | 1 | Interrupt line toward the CPU |

## Verification
The bench builds the block with the package defaults: an internal base of 32, 32 configurable lines, 5-bit slot numbers and 2-bit pins. These values bring the whole board map into reach, including the first and last expansion slots, the top mapped number 45, and slots just outside each range (4 and 13) that must pass through. The 32-bit configuration words also let the bench set every bit except the indexed one in the opposite sense. This shows that only the bit selected by the mapped index steers the CPU line.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    parameter int LINE_BASE = 32;
    parameter int NUM_LINES = 32;
    parameter int SLOT_W    = 5;
    parameter int PIN_W     = 2;
    localparam int NUM_W    = $clog2(LINE_BASE + NUM_LINES);
    localparam int IDX_W    = $clog2(NUM_LINES);

    // board map
    parameter int SB_SLOT   = 5;
    parameter int VID_SLOT  = 6;
    parameter int NIC_SLOT  = 7;
    parameter int VID_LINE  = 4;
    parameter int NIC_LINE  = 5;
    parameter int EXP_FIRST = 8;
    parameter int EXP_LAST  = 12;
    parameter int EXP_LINE0 = 6;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } route_t;

    function automatic route_t decode_route(input logic [NUM_W-1:0] num);
        route_t r;
        r.hit = (int'(num) >= LINE_BASE);
        r.idx = IDX_W'(int'(num) - LINE_BASE);
        return r;
    endfunction
endpackage

// File: rtl/slot_pin_mapper.sv
module slot_pin_mapper
    import irq_route_pkg::*;
(
    input  logic [SLOT_W-1:0] slot,
    input  logic [PIN_W-1:0]  pin,
    output logic [NUM_W-1:0]  num
);
    logic [1:0] pin_mod4;
    int         slot_i;

    assign pin_mod4 = pin[1:0];
    assign slot_i   = int'(slot);

    always_comb begin
        if (slot_i == SB_SLOT)
            num = NUM_W'(LINE_BASE + int'(pin_mod4));
        else if (slot_i == VID_SLOT)
            num = NUM_W'(LINE_BASE + VID_LINE);
        else if (slot_i == NIC_SLOT)
            num = NUM_W'(LINE_BASE + NIC_LINE);
        else if (slot_i >= EXP_FIRST && slot_i <= EXP_LAST)
            num = NUM_W'(LINE_BASE + EXP_LINE0 + (slot_i - EXP_FIRST) + int'(pin));
        else
            num = NUM_W'(pin);
    end

    always_comb begin
        if (slot_i == VID_SLOT || slot_i == NIC_SLOT)
            assert_fixed_line_R3: assert (int'(num) >= LINE_BASE + VID_LINE
                                          && int'(num) <= LINE_BASE + NIC_LINE)
                else $error("fixed slot left its line range");
    end
endmodule

// File: rtl/irq_line_driver.sv
module irq_line_driver
    import irq_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fire,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_LINES-1:0] edge_sel,
    input  logic [NUM_LINES-1:0] line_pol,
    output logic                 cpu_irq
);
    typedef enum logic [1:0] {DRV_HOLD, DRV_PULSE, DRV_LEVEL} drv_op_e;

    drv_op_e op;
    logic    line_q;
    logic    pulse_q;

    always_comb begin
        if (fire)
            op = edge_sel[idx] ? DRV_PULSE : DRV_LEVEL;
        else
            op = DRV_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            unique case (op)
                DRV_PULSE: begin
                    line_q  <= 1'b1;
                    pulse_q <= 1'b1;
                end
                DRV_LEVEL: begin
                    line_q  <= line_pol[idx];
                    pulse_q <= 1'b0;
                end
                default: begin
                    if (pulse_q) line_q <= 1'b0;
                    pulse_q <= 1'b0;
                end
            endcase
        end
    end

    assign cpu_irq = line_q;

    assert_pulse_high_R6: assert property (@(posedge clk) disable iff (rst)
        fire && edge_sel[idx] |=> cpu_irq);
    assert_pulse_ends_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && edge_sel[idx]) ##1 !fire |=> !cpu_irq);
    assert_level_follows_pol_R7: assert property (@(posedge clk) disable iff (rst)
        fire && !edge_sel[idx] |=> cpu_irq == $past(line_pol[idx]));
    assert_level_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !fire && !pulse_q |=> $stable(cpu_irq));
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
    import irq_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [SLOT_W-1:0]    req_slot,
    input  logic [PIN_W-1:0]     req_pin,
    input  logic [NUM_LINES-1:0] edge_sel,
    input  logic [NUM_LINES-1:0] line_pol,
    output logic [NUM_W-1:0]     mapped_num,
    output logic                 cpu_irq
);
    route_t route;
    logic   fire;

    slot_pin_mapper u_map (
        .slot (req_slot),
        .pin  (req_pin),
        .num  (mapped_num)
    );

    assign route = decode_route(mapped_num);
    assign fire  = req_valid && route.hit;

    irq_line_driver u_drv (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .idx      (route.idx),
        .edge_sel (edge_sel),
        .line_pol (line_pol),
        .cpu_irq  (cpu_irq)
    );

    assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid && (int'(mapped_num) < LINE_BASE) && !$past(fire) |=> $stable(cpu_irq));
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !cpu_irq);
endmodule

// File: tb/tb_pci_irq_router.sv
module tb_pci_irq_router;
    import irq_route_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic [SLOT_W-1:0]    req_slot = '0;
    logic [PIN_W-1:0]     req_pin = '0;
    logic [NUM_LINES-1:0] edge_sel = '0;
    logic [NUM_LINES-1:0] line_pol = '0;
    logic [NUM_W-1:0]     mapped_num;
    logic                 cpu_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    pci_irq_router dut (.*);

    // {slot[4:0], pin[1:0], expected number[5:0]}
    localparam int NV = 15;
    localparam logic [12:0] VEC [NV] = '{
        {5'd5,  2'd0, 6'd32}, {5'd5,  2'd3, 6'd35}, {5'd6,  2'd0, 6'd36},
        {5'd6,  2'd3, 6'd36}, {5'd7,  2'd1, 6'd37}, {5'd8,  2'd0, 6'd38},
        {5'd8,  2'd3, 6'd41}, {5'd10, 2'd1, 6'd41}, {5'd12, 2'd3, 6'd45},
        {5'd12, 2'd0, 6'd42}, {5'd0,  2'd2, 6'd2},  {5'd13, 2'd1, 6'd1},
        {5'd31, 2'd3, 6'd3},  {5'd4,  2'd0, 6'd0},  {5'd9,  2'd2, 6'd41}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // strobe a request for one cycle; return at the negedge after it is taken
    task automatic request(input int slot, input int pin);
        req_slot  = SLOT_W'(slot);
        req_pin   = PIN_W'(pin);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset line", 32'(cpu_irq), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 32'(cpu_irq), 0);

        // mapping table, R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            req_slot = VEC[i][12:8];
            req_pin  = VEC[i][7:6];
            #1;
            if (int'(VEC[i][12:8]) == 5)
                check("R2 slot5 map", 32'(mapped_num), 32'(VEC[i][5:0]));
            else if (int'(VEC[i][12:8]) == 6 || int'(VEC[i][12:8]) == 7)
                check("R3 fixed slot map", 32'(mapped_num), 32'(VEC[i][5:0]));
            else if (int'(VEC[i][12:8]) >= 8 && int'(VEC[i][12:8]) <= 12)
                check("R4 expansion map", 32'(mapped_num), 32'(VEC[i][5:0]));
            else
                check("R5 pass through", 32'(mapped_num), 32'(VEC[i][5:0]));
        end
        @(negedge clk);

        // R6 edge pulse: slot 7 -> index 5
        edge_sel = 32'h0000_0020;
        line_pol = 32'h0;
        request(7, 0);
        check("R6 pulse high", 32'(cpu_irq), 1);
        @(negedge clk);
        check("R6 pulse ends", 32'(cpu_irq), 0);
        @(negedge clk);
        check("R6 stays low", 32'(cpu_irq), 0);

        // R7 level high: slot 6 -> index 4
        edge_sel = 32'h0;
        line_pol = 32'h0000_0010;
        request(6, 2);
        check("R7 level high", 32'(cpu_irq), 1);
        repeat (3) @(negedge clk);
        check("R9 level held", 32'(cpu_irq), 1);
        line_pol = 32'h0;
        edge_sel = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        check("R9 config change no effect", 32'(cpu_irq), 1);

        // R10 unmapped request leaves line high
        edge_sel = 32'h0;
        line_pol = 32'h0;
        request(0, 3);
        check("R10 unmapped ignored", 32'(cpu_irq), 1);
        request(13, 1);
        check("R10 unmapped slot 13", 32'(cpu_irq), 1);

        // R8 only indexed bit: slot 5 pin 0 -> index 0
        edge_sel = 32'hFFFF_FFFE;
        line_pol = 32'hFFFF_FFFE;
        request(5, 0);
        check("R8 level low by index bit", 32'(cpu_irq), 0);
        @(negedge clk);
        check("R8 low held", 32'(cpu_irq), 0);

        // R7 on expansion slot 12 pin 3 -> index 13
        edge_sel = 32'h0;
        line_pol = 32'h0000_2000;
        request(12, 3);
        check("R7 expansion level high", 32'(cpu_irq), 1);

        // R6 pulse from a high level ends low: slot 8 pin 1 -> index 7
        edge_sel = 32'h0000_0080;
        line_pol = 32'hFFFF_FFFF;
        request(8, 1);
        check("R6 pulse over level", 32'(cpu_irq), 1);
        @(negedge clk);
        check("R6 pulse over level ends", 32'(cpu_irq), 0);

        // R1 reset clears a held level
        edge_sel = 32'h0;
        request(5, 2);
        check("R7 slot5 pin2 level", 32'(cpu_irq), 1);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears line", 32'(cpu_irq), 0);
        rst = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule